// File: doc/BRIEF.md
# DRAM Posted Refresh Scheduler

This block decides when a DRAM controller should spend a cycle on an AUTO REFRESH command. An internal interval timer adds one owed refresh every average refresh interval. The controller may defer owed refreshes while traffic is heavy, up to eight. When eight are owed, the block raises an urgent flag that stays up until a refresh is taken. When the controller reports the device idle, the block also offers refreshes in advance, up to eight ahead. It keeps these as a negative balance, and later timer ticks pay that balance back before they create new requests.

The handshake is plain level control, not a data stream, so it has no back-pressure. `req_o` means a refresh may be taken now. The controller takes it by pulsing `ack_i` for one cycle while `req_o` is high, at the same moment it issues AUTO REFRESH. An ack seen while `req_o` is low is dropped. After each accepted ack, `busy_o` covers the refresh command period so that the controller sends nothing else to the device. The refresh interval and the refresh command period are given in picoseconds together with the clock period, and the block converts them to cycles.

Top module: `refresh_scheduler`

## Requirements
- R1: While the synchronous reset `rst_i` is high, and on the first cycle after it drops, `req_o`, `urgent_o` and `busy_o` are low and the balance is zero.
- R2: Every REFI_CYC cycles after reset, the balance rises by one. Whenever the balance is positive and `busy_o` is low, `req_o` is high, whatever `idle_i` is.
- R3: An accepted ack (`ack_i` high while `req_o` is high) lowers the balance by one. It drives `busy_o` high from the next cycle for exactly RFC_CYC cycles.
- R4: The balance never exceeds MAX_POST (8). A tick that arrives at that level is dropped.
- R5: `urgent_o` is high exactly while the balance equals MAX_POST. It falls only in the cycle after an accepted ack.
- R6: With `idle_i` high, `busy_o` low and a balance of zero or below but above -MAX_PULL, `req_o` is high. An ack then drives the balance negative.
- R7: The balance never goes below -MAX_PULL (-8). At that level `req_o` stays low even with `idle_i` high.
- R8: While the balance is negative, a tick raises it toward zero and asserts no request with `idle_i` low.
- R9: An ack while `req_o` is low, including one while `busy_o` is high, has no effect on the balance or on `busy_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| idle_i | input | 1 | Controller reports no pending traffic, so refreshes may be taken in advance |
| ack_i | input | 1 | One-cycle pulse: AUTO REFRESH issued this cycle |
| req_o | output | 1 | A refresh may be taken now |
| urgent_o | output | 1 | The deferral limit is reached and a refresh must be taken |
| busy_o | output | 1 | Refresh command period in progress |

## Verification
Two states are the hardest to reach from the ports: the full negative credit of eight, and a tick that arrives when eight refreshes are already owed. Neither can be seen directly. The stimulus reaches them by aligning every batch of acks to the cycle just after a timer tick, so that a burst of eight acks finishes before the next tick. Each level is then proven by a following window of ticks in which `req_o` must stay low or `urgent_o` must clear only after an exact number of acks. A further directed case sends an ack while `busy_o` is high. It then shows the dropped ack through the number of accepted acks needed to clear `req_o`.

// File: rtl/rfsh_sched_pkg.sv
package rfsh_sched_pkg;
  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  function automatic int cnt_w(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/rfsh_tick_gen.sv
module rfsh_tick_gen
  import rfsh_sched_pkg::*;
#(
  parameter int PERIOD = 1560
) (
  input  logic clk_i,
  input  logic rst_i,
  output logic tick_o
);
  localparam int W = cnt_w(PERIOD);
  localparam logic [W-1:0] LAST = W'(PERIOD - 1);

  logic [W-1:0] cnt;

  assign tick_o = (cnt == LAST);

  always_ff @(posedge clk_i) begin
    if (rst_i || tick_o) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rfsh_owed_ledger.sv
module rfsh_owed_ledger
  import rfsh_sched_pkg::*;
#(
  parameter int MAX_POST = 8,
  parameter int MAX_PULL = 8
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic tick_i,
  input  logic take_i,
  output logic owed_o,
  output logic room_o,
  output logic full_o
);
  localparam int BW = cnt_w(max2(MAX_POST, MAX_PULL) + 1) + 1;
  localparam logic signed [BW-1:0] CEIL_S  = BW'(MAX_POST);
  localparam logic signed [BW-1:0] FLOOR_S = BW'(-MAX_PULL);
  localparam logic signed [BW-1:0] ONE_S   = BW'(1);

  logic signed [BW-1:0] bal, nxt, inc, dec;

  always_comb begin
    inc = tick_i ? ONE_S : '0;
    dec = take_i ? ONE_S : '0;
    nxt = bal + inc - dec;
    if (nxt > CEIL_S) nxt = CEIL_S;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) bal <= '0;
    else       bal <= nxt;
  end

  assign owed_o = (bal > 0);
  assign room_o = (bal > FLOOR_S);
  assign full_o = (bal == CEIL_S);
endmodule

// File: rtl/rfsh_busy_timer.sv
module rfsh_busy_timer
  import rfsh_sched_pkg::*;
#(
  parameter int CYC = 8
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic start_i,
  output logic busy_o
);
  localparam int W = cnt_w(CYC);

  logic [W-1:0] left;

  always_ff @(posedge clk_i) begin
    if (rst_i)             left <= '0;
    else if (start_i)      left <= W'(CYC);
    else if (left != '0)   left <= left - 1'b1;
  end

  assign busy_o = (left != '0);
endmodule

// File: rtl/refresh_scheduler.sv
module refresh_scheduler
  import rfsh_sched_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 10_000,
  parameter int REFI_PS       = 15_600_000,
  parameter int RFC_PS        = 75_000,
  parameter int MAX_POST      = 8,
  parameter int MAX_PULL      = 8
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic idle_i,
  input  logic ack_i,
  output logic req_o,
  output logic urgent_o,
  output logic busy_o
);
  localparam int REFI_CYC = REFI_PS / CLK_PERIOD_PS;
  localparam int RFC_CYC  = ceil_div(RFC_PS, CLK_PERIOD_PS);

  logic tick, take, owed, room, full;

  rfsh_tick_gen #(.PERIOD(REFI_CYC)) tick_i (
    .clk_i(clk_i), .rst_i(rst_i), .tick_o(tick)
  );

  rfsh_owed_ledger #(.MAX_POST(MAX_POST), .MAX_PULL(MAX_PULL)) ledger_i (
    .clk_i(clk_i), .rst_i(rst_i), .tick_i(tick), .take_i(take),
    .owed_o(owed), .room_o(room), .full_o(full)
  );

  rfsh_busy_timer #(.CYC(RFC_CYC)) busy_i (
    .clk_i(clk_i), .rst_i(rst_i), .start_i(take), .busy_o(busy_o)
  );

  assign req_o    = !busy_o && (owed || (idle_i && room));
  assign take     = ack_i && req_o;
  assign urgent_o = full;
endmodule

// File: rtl/rfsh_sched_chk.sv
module rfsh_sched_chk
  import rfsh_sched_pkg::*;
#(
  parameter int RFC_CYC = 8
) (
  input logic clk_i,
  input logic rst_i,
  input logic idle_i,
  input logic ack_i,
  input logic req_o,
  input logic urgent_o,
  input logic busy_o
);
  localparam int W = cnt_w(RFC_CYC) + 1;
  logic [W-1:0] run;

  always_ff @(posedge clk_i) begin
    if (rst_i)       run <= '0;
    else if (busy_o) run <= run + 1'b1;
    else             run <= '0;
  end

  // R3
  busy_start_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(busy_o) |-> $past(ack_i && req_o));

  // R3
  busy_len_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    busy_o |-> (run < W'(RFC_CYC)));

  // R5
  urgent_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(urgent_o) |-> $past(ack_i && req_o));

  // R2
  urgent_req_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (urgent_o && !busy_o) |-> req_o);

  // R9
  busy_no_req_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    busy_o |-> !req_o);
endmodule

bind refresh_scheduler rfsh_sched_chk #(.RFC_CYC(RFC_CYC)) chk_i (.*);

// File: tb/refresh_scheduler_tb_top.sv
module refresh_scheduler_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int REFI = 64;
  localparam int RFC  = 3;

  typedef struct packed {
    logic       op_ack;
    logic [3:0] n;
    logic       idle;
    logic       acc;
    logic       req;
    logic       urg;
  } step_t;

  localparam int NSTEP = 13;
  localparam step_t TBL [NSTEP] = '{
    '{1'b0, 4'd1, 1'b0, 1'b0, 1'b1, 1'b0},
    '{1'b1, 4'd1, 1'b0, 1'b1, 1'b0, 1'b0},
    '{1'b0, 4'd8, 1'b0, 1'b0, 1'b1, 1'b1},
    '{1'b0, 4'd1, 1'b0, 1'b0, 1'b1, 1'b1},
    '{1'b1, 4'd1, 1'b0, 1'b1, 1'b1, 1'b0},
    '{1'b1, 4'd7, 1'b0, 1'b1, 1'b0, 1'b0},
    '{1'b1, 4'd1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b0, 4'd1, 1'b0, 1'b0, 1'b1, 1'b0},
    '{1'b1, 4'd1, 1'b0, 1'b1, 1'b0, 1'b0},
    '{1'b1, 4'd8, 1'b1, 1'b1, 1'b0, 1'b0},
    '{1'b1, 4'd1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{1'b0, 4'd8, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b0, 4'd1, 1'b0, 1'b0, 1'b1, 1'b0}
  };

  logic clk = 1'b0;
  logic rst, idle, ack;
  logic req, urgent, busy;
  int   ec;
  int   checks = 0;
  int   errors = 0;

  always #5 clk = ~clk;

  refresh_scheduler #(
    .CLK_PERIOD_PS(10_000), .REFI_PS(REFI * 10_000), .RFC_PS(RFC * 10_000),
    .MAX_POST(8), .MAX_PULL(8)
  ) dut_i (
    .clk_i(clk), .rst_i(rst), .idle_i(idle), .ack_i(ack),
    .req_o(req), .urgent_o(urgent), .busy_o(busy)
  );

  always @(posedge clk) begin
    if (rst) ec <= 0;
    else     ec <= ec + 1;
  end

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at cycle %0d", tag, act, exp, ec);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic wait_ticks(input int n);
    int target;
    target = (ec / REFI + n) * REFI;
    while (ec < target) @(negedge clk);
  endtask

  // one ack pulse, then the refresh command period; checks busy start and end
  task automatic do_ack(input logic exp_acc);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    check("R3/R9 busy after ack", busy, exp_acc);
    repeat (RFC) @(negedge clk);
    check("R3 busy ended", busy, 1'b0);
  endtask

  initial begin
    repeat (150_000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; idle = 1'b0; ack = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 req in reset", req, 1'b0);
    check("R1 urgent in reset", urgent, 1'b0);
    check("R1 busy in reset", busy, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 req after reset", req, 1'b0);
    idle = 1'b1;
    #1;
    check("R1 R6 idle offer from zero", req, 1'b1);
    idle = 1'b0;
    #1;

    // table: R2 R4 R5 R6 R7 R8 R9
    for (int i = 0; i < NSTEP; i++) begin
      idle = TBL[i].idle;
      if (TBL[i].op_ack) begin
        for (int k = 0; k < int'(TBL[i].n); k++) do_ack(TBL[i].acc);
      end else begin
        wait_ticks(int'(TBL[i].n));
      end
      #1;
      check($sformatf("R2/R6/R7/R8 req step %0d", i), req, TBL[i].req);
      check($sformatf("R4/R5 urgent step %0d", i), urgent, TBL[i].urg);
    end

    // R9: ack while busy is dropped (balance 1 -> 3)
    idle = 1'b0;
    wait_ticks(2);
    ack = 1'b1;
    @(negedge clk);
    check("R3 busy after first ack", busy, 1'b1);
    @(negedge clk);
    ack = 1'b0;
    check("R9 busy still on", busy, 1'b1);
    @(negedge clk);
    check("R9 busy kept its length", busy, 1'b1);
    @(negedge clk);
    check("R9 busy not extended", busy, 1'b0);
    check("R9 req with two owed", req, 1'b1);
    do_ack(1'b1);
    #1;
    check("R9 req with one owed", req, 1'b1);
    do_ack(1'b1);
    #1;
    check("R9 req cleared", req, 1'b0);

    finish_run();
  end
endmodule